// File: doc/BRIEF.md
# Flash Sector Erase Command Sequencer

This block sits on the device side of one NOR-style flash bank. It watches the bank's write cycles, each given as a word address, a data byte and a one-cycle write strobe. It recognises the six-write sector erase command. The last write of that command names a sector. That write opens a timed acceptance window, and during the window the host may name more sectors of the same bank. Each sector it names joins a bitmap of sectors marked for erase.

When the window runs out with no new sector written, the sequencer starts the embedded erase. Here the erase is modelled as a fixed busy count. Once the count ends, the bank goes back to array reads and the bitmap is cleared. A timer-status output shows that the window has closed. A ready/busy output is low while the window is open and while the erase runs. A suspend command can pause the operation, and writing the sector code again resumes it.

Top module: `sector_erase_seq`

## Requirements
- R1: After a synchronous reset, `ready` is 1, `win_expired` is 0 and `erase_sel` is all zeros.
- R2: The command is six consecutive writes, in this order: AAh at 555h, 55h at 2AAh, 80h at 555h, AAh at 555h, 55h at 2AAh, and then 30h at any address. Only address bits [10:0] are compared for the fixed addresses. The sector number is address bits [ADDR_W-1 -: SECT_W]. In the cycle after the sixth write, `ready` is 0, `win_expired` is 0 and `erase_sel` holds only the bit of that sector.
- R3: A write that does not match its expected data or address during the first five writes returns the decoder to read mode. A 30h write that follows then starts nothing.
- R4: While the window is open, a 30h write ORs its sector bit into `erase_sel` and restarts the window count from zero.
- R5: When WIN_CYC clock cycles pass with no write after the last accepted 30h write, the erase starts and `win_expired` becomes 1. A 30h write on the WIN_CYC-th idle edge is still accepted.
- R6: While the window is open, a write that is neither 30h nor B0h aborts the operation. In the next cycle `ready` is 1, `win_expired` is 0 and `erase_sel` is zero.
- R7: While the erase runs, every write other than B0h is ignored. `erase_sel` does not change and the erase ends on schedule.
- R8: The erase lasts ERASE_CYC cycles. After it, `ready` is 1, `win_expired` is 0 and `erase_sel` is zero.
- R9: A B0h write during the window or the erase suspends the operation at once. While suspended, `ready` is 1, `win_expired` is 1, `erase_sel` is kept and the erase count is frozen. Other writes are ignored. A 30h write resumes the erase with the count it had.
- R10: Asserting reset during an erase ends it at once and returns the bank to read mode with `erase_sel` cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| wr_en | input | 1 | One-cycle bus write strobe |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 8 | Data byte of the write |
| ready | output | 1 | High when the bank serves array reads; low while the window is open or the erase runs |
| win_expired | output | 1 | Timer status: high once the acceptance window has closed |
| erase_sel | output | 2**SECT_W | Bitmap of the sectors marked for erase |

## Verification
The bench places the added sector on the last idle edge of the window. A sequencer whose count is off by one then either drops that sector or starts the erase one cycle early. It corrupts each of the first five writes in turn, once in the data and once in the address. A decoder that only checks data, or that resynchronises too eagerly, would then start an erase. It sends unlock-like writes and 30h writes during the erase, and it sends a suspend during both the window and the erase. A design that counted while suspended, lost the bitmap, or let a 30h write add sectors after the erase had started would end on the wrong cycle or report the wrong bitmap.

// File: rtl/sese_pkg.sv
package sese_pkg;

    typedef enum logic [3:0] {
        ST_READ,
        ST_C1,
        ST_C2,
        ST_C3,
        ST_C4,
        ST_C5,
        ST_WINDOW,
        ST_ERASE,
        ST_SUSP
    } seq_state_e;

    typedef enum logic [2:0] {
        K_UNLOCK_A,
        K_UNLOCK_B,
        K_SETUP,
        K_SECTOR,
        K_SUSPEND,
        K_OTHER
    } cmd_kind_e;

    localparam logic [10:0] ADDR_KEY_A   = 11'h555;
    localparam logic [10:0] ADDR_KEY_B   = 11'h2AA;
    localparam logic [7:0]  CODE_KEY_A   = 8'hAA;
    localparam logic [7:0]  CODE_KEY_B   = 8'h55;
    localparam logic [7:0]  CODE_SETUP   = 8'h80;
    localparam logic [7:0]  CODE_SECTOR  = 8'h30;
    localparam logic [7:0]  CODE_SUSPEND = 8'hB0;

    function automatic cmd_kind_e classify(input logic [10:0] a, input logic [7:0] d);
        cmd_kind_e k;
        k = K_OTHER;
        if (d == CODE_KEY_A && a == ADDR_KEY_A)      k = K_UNLOCK_A;
        else if (d == CODE_KEY_B && a == ADDR_KEY_B) k = K_UNLOCK_B;
        else if (d == CODE_SETUP && a == ADDR_KEY_A) k = K_SETUP;
        else if (d == CODE_SECTOR)                   k = K_SECTOR;
        else if (d == CODE_SUSPEND)                  k = K_SUSPEND;
        return k;
    endfunction

endpackage

// File: rtl/sese_cmd_decode.sv
module sese_cmd_decode
    import sese_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data,
    input  logic [ADDR_W-12:0] unused_hi,
    output cmd_kind_e         kind
);
    logic unused_ok;
    assign unused_ok = ^unused_hi;
    assign kind = classify(addr[10:0], data);
endmodule

// File: rtl/sese_cycle_timer.sv
module sese_cycle_timer #(
    parameter int LIMIT = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    output logic done
);
    localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] count;

    assign done = run && (count == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear)  count <= '0;
        else if (done)     count <= '0;
        else if (run)      count <= count + 1'b1;
    end

    // R5
    timer_range_chk: assert property (@(posedge clk) disable iff (rst)
        count <= LAST);
endmodule

// File: rtl/sector_erase_seq.sv
module sector_erase_seq
    import sese_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int SECT_W    = 3,
    parameter int WIN_CYC   = 20,
    parameter int ERASE_CYC = 30
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [7:0]               wr_data,
    output logic                     ready,
    output logic                     win_expired,
    output logic [(1<<SECT_W)-1:0]   erase_sel
);
    localparam int NUM_SECT = 1 << SECT_W;

    seq_state_e          state, state_n;
    logic [NUM_SECT-1:0] sel_n;
    cmd_kind_e           kind;
    logic [SECT_W-1:0]   sect;
    logic [NUM_SECT-1:0] sect_bit;
    logic                win_clear, win_run, win_done;
    logic                ers_clear, ers_run, ers_done;
    logic                is_sector, is_suspend;

    sese_cmd_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr      (wr_addr),
        .data      (wr_data),
        .unused_hi (wr_addr[ADDR_W-1:11]),
        .kind      (kind)
    );

    assign sect       = wr_addr[ADDR_W-1 -: SECT_W];
    assign sect_bit   = NUM_SECT'(1) << sect;
    assign is_sector  = wr_en && (kind == K_SECTOR);
    assign is_suspend = wr_en && (kind == K_SUSPEND);

    assign win_clear = is_sector && (state == ST_C5 || state == ST_WINDOW);
    assign win_run   = (state == ST_WINDOW) && !wr_en;
    assign ers_clear = is_sector && (state == ST_C5);
    assign ers_run   = (state == ST_ERASE) && !is_suspend;

    sese_cycle_timer #(.LIMIT(WIN_CYC)) u_win_timer (
        .clk (clk), .rst (rst), .clear (win_clear), .run (win_run), .done (win_done)
    );

    sese_cycle_timer #(.LIMIT(ERASE_CYC)) u_erase_timer (
        .clk (clk), .rst (rst), .clear (ers_clear), .run (ers_run), .done (ers_done)
    );

    always_comb begin
        state_n = state;
        sel_n   = erase_sel;
        unique case (state)
            ST_READ:   if (wr_en && kind == K_UNLOCK_A) state_n = ST_C1;
            ST_C1:     if (wr_en) state_n = (kind == K_UNLOCK_B) ? ST_C2 : ST_READ;
            ST_C2:     if (wr_en) state_n = (kind == K_SETUP)    ? ST_C3 : ST_READ;
            ST_C3:     if (wr_en) state_n = (kind == K_UNLOCK_A) ? ST_C4 : ST_READ;
            ST_C4:     if (wr_en) state_n = (kind == K_UNLOCK_B) ? ST_C5 : ST_READ;
            ST_C5: begin
                if (is_sector) begin
                    state_n = ST_WINDOW;
                    sel_n   = sect_bit;
                end else if (wr_en) begin
                    state_n = ST_READ;
                end
            end
            ST_WINDOW: begin
                if (is_sector) begin
                    sel_n = erase_sel | sect_bit;
                end else if (is_suspend) begin
                    state_n = ST_SUSP;
                end else if (wr_en) begin
                    state_n = ST_READ;
                    sel_n   = '0;
                end else if (win_done) begin
                    state_n = ST_ERASE;
                end
            end
            ST_ERASE: begin
                if (is_suspend) begin
                    state_n = ST_SUSP;
                end else if (ers_done) begin
                    state_n = ST_READ;
                    sel_n   = '0;
                end
            end
            ST_SUSP:   if (is_sector) state_n = ST_ERASE;
            default:   state_n = ST_READ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_READ;
            erase_sel <= '0;
        end else begin
            state     <= state_n;
            erase_sel <= sel_n;
        end
    end

    assign ready       = !(state == ST_WINDOW || state == ST_ERASE);
    assign win_expired = (state == ST_ERASE) || (state == ST_SUSP);

    // R7
    erase_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ERASE && wr_en && kind != K_SUSPEND && !ers_done) |=> $stable(erase_sel));

    // R6
    stray_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WINDOW && wr_en && kind != K_SECTOR && kind != K_SUSPEND)
        |=> (ready && !win_expired && erase_sel == '0));

    // R8
    erase_finish_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ERASE && ers_done) |=> (ready && !win_expired && erase_sel == '0));

    // R5
    expire_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(win_expired) |-> ($past(state) == ST_WINDOW));

    // R4
    sector_add_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WINDOW && is_sector)
        |=> (((erase_sel & $past(sect_bit)) != '0) &&
             ((erase_sel & $past(erase_sel)) == $past(erase_sel))));

    // R2
    busy_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ready) |-> ($past(state) == ST_C5 || $past(state) == ST_SUSP));

    // R9
    suspend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SUSP && !is_sector) |=> ($stable(erase_sel) && ready && win_expired));
endmodule

// File: tb/sector_erase_seq_tb.sv
module sector_erase_seq_tb;
    localparam int ADDR_W = 14;
    localparam int SECT_W = 3;
    localparam int WIN    = 20;
    localparam int ERS    = 30;

    logic              clk = 1'b0;
    logic              rst;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;
    logic              ready;
    logic              win_expired;
    logic [7:0]        erase_sel;

    int vectors = 0;
    int fails   = 0;

    always #5 clk = ~clk;

    sector_erase_seq #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .WIN_CYC(WIN), .ERASE_CYC(ERS)) u_dut (
        .clk (clk), .rst (rst), .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
        .ready (ready), .win_expired (win_expired), .erase_sel (erase_sel)
    );

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic state_chk(input string tag, input int r, input int w, input int s);
        chk({tag, " ready"}, int'(ready), r);
        chk({tag, " win_expired"}, int'(win_expired), w);
        chk({tag, " erase_sel"}, int'(erase_sel), s);
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [ADDR_W-1:0] saddr(input int s);
        return {s[2:0], 11'h0AB};
    endfunction

    task automatic full_seq(input int s);
        wr(14'h555, 8'hAA);
        wr(14'h2AA, 8'h55);
        wr(14'h555, 8'h80);
        wr(14'h555, 8'hAA);
        wr(14'h2AA, 8'h55);
        wr(saddr(s), 8'h30);
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [ADDR_W-1:0] sa [6];
        logic [7:0]        sd [6];
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        idle(3);
        rst = 1'b0;
        idle(1);
        state_chk("R1 reset", 1, 0, 0);

        // R2 / R6: every sector, then a stray write aborts
        for (int s = 0; s < 8; s++) begin
            full_seq(s);
            state_chk("R2 window open", 0, 0, 1 << s);
            if (s[0]) wr(14'h0123, 8'hF0);
            else      wr(14'h555, 8'hAA);
            state_chk("R6 stray abort", 1, 0, 0);
        end

        // R3: corrupt each of the first five writes, in data and in address
        sa[0] = 14'h555; sd[0] = 8'hAA;
        sa[1] = 14'h2AA; sd[1] = 8'h55;
        sa[2] = 14'h555; sd[2] = 8'h80;
        sa[3] = 14'h555; sd[3] = 8'hAA;
        sa[4] = 14'h2AA; sd[4] = 8'h55;
        sa[5] = saddr(2); sd[5] = 8'h30;
        for (int mode = 0; mode < 2; mode++) begin
            for (int i = 0; i < 5; i++) begin
                for (int j = 0; j < 6; j++) begin
                    if (j == i && mode == 0) wr(sa[j], sd[j] ^ 8'h01);
                    else if (j == i)         wr(sa[j] ^ 14'h001, sd[j]);
                    else                     wr(sa[j], sd[j]);
                end
                state_chk("R3 mismatch", 1, 0, 0);
            end
        end

        // R4 / R5 / R8: restart window, expiry on exact cycle, erase length
        full_seq(1);
        idle(10);
        wr(saddr(6), 8'h30);
        state_chk("R4 added sector", 0, 0, 8'h42);
        idle(WIN - 1);
        state_chk("R5 window still open", 0, 0, 8'h42);
        idle(1);
        state_chk("R5 window expired", 0, 1, 8'h42);
        idle(ERS - 1);
        state_chk("R8 erase still busy", 0, 1, 8'h42);
        idle(1);
        state_chk("R8 erase done", 1, 0, 0);

        // R5 / R10: gap sweep incl. last idle edge, exit by reset
        for (int k = 0; k < 3; k++) begin
            int g;
            g = (k == 0) ? 1 : ((k == 1) ? 7 : WIN - 1);
            full_seq(2);
            idle(g);
            wr(saddr(3), 8'h30);
            state_chk("R5 late add accepted", 0, 0, 8'h0C);
            idle(WIN - 1);
            chk("R5 open before limit", int'(win_expired), 0);
            idle(1);
            chk("R5 expired at limit", int'(win_expired), 1);
            idle(4);
            rst = 1'b1;
            @(negedge clk);
            rst = 1'b0;
            state_chk("R10 reset ends erase", 1, 0, 0);
        end
        wr(saddr(1), 8'h30);
        state_chk("R10 no stale command", 1, 0, 0);

        // R7: writes during erase ignored
        full_seq(4);
        idle(WIN);
        state_chk("R7 erase started", 0, 1, 8'h10);
        wr(14'h555, 8'hAA);
        wr(14'h2AA, 8'h55);
        wr(14'h555, 8'h80);
        wr(saddr(0), 8'h30);
        state_chk("R7 writes ignored", 0, 1, 8'h10);
        idle(ERS - 5);
        state_chk("R7 erase still busy", 0, 1, 8'h10);
        idle(1);
        state_chk("R7 erase on schedule", 1, 0, 0);

        // R9: suspend during erase, count frozen
        full_seq(0);
        idle(WIN);
        idle(5);
        wr(14'h0100, 8'hB0);
        state_chk("R9 suspended", 1, 1, 8'h01);
        idle(10);
        wr(14'h0005, 8'hF0);
        state_chk("R9 write ignored in suspend", 1, 1, 8'h01);
        wr(saddr(0), 8'h30);
        state_chk("R9 resumed", 0, 1, 8'h01);
        idle(ERS - 6);
        state_chk("R9 resumed busy", 0, 1, 8'h01);
        idle(1);
        state_chk("R9 resumed finish", 1, 0, 0);

        // R9: suspend during window
        full_seq(7);
        idle(3);
        wr(14'h0200, 8'hB0);
        state_chk("R9 window suspend", 1, 1, 8'h80);
        idle(WIN + 5);
        state_chk("R9 window suspend held", 1, 1, 8'h80);
        wr(saddr(7), 8'h30);
        state_chk("R9 window resume", 0, 1, 8'h80);
        idle(ERS - 1);
        chk("R9 window resume busy", int'(ready), 0);
        idle(1);
        state_chk("R9 window resume done", 1, 0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule